// File: doc/BRIEF.md
# Atomic Operation Completer Engine

This block carries out one atomic request at a time against a local word-wide memory. The supported operations are fetch-and-add, swap and compare-and-swap. A request gives the operation code, a byte address, a length in doublewords and a little-endian operand payload. The engine first checks the request. It then reads the target word, computes the new value and writes back only the bytes of the operand. Finally it reports the original contents as completion data.

Requests are refused when they use the reserved operation code, when the length does not match a legal operand size for the operation, or when the address is not naturally aligned to the operand size. A refused request returns a status code and never touches memory. Because only one request is in flight at a time, a request always sees the write of the request before it, including one aimed at the same address. The memory port is synchronous: read data comes back on the cycle after the read strobe.

Top module: `atomic_completer`

## Requirements
- R1: Operation codes are 0 fetch-and-add, 1 swap and 2 compare-and-swap. Code 3 is refused with status 1 (unsupported) and causes no memory read or write.
- R2: For codes 0 and 1, a length of 1 or 2 doublewords gives an operand of 4 or 8 bytes. For code 2, lengths 2, 4 and 8 give operands of 4, 8 or 16 bytes. Any other length is refused with status 2 (malformed) and causes no memory access. The operation-code check takes priority over the length check.
- R3: A legal-length request whose byte address is not a multiple of the operand size is refused with status 2 and causes no memory access.
- R4: Payload byte k sits at bits [8k+7:8k] and is byte k of the first operand, counting from the least significant byte. For compare-and-swap, the compare value fills the first S bytes and the swap value fills the next S bytes, in the same order.
- R5: An accepted request reads the target before any write. Its completion carries status 0 and the original operand value in the low S bytes of the completion data, with the upper bytes zero.
- R6: Fetch-and-add writes (original + addend) modulo 2^(8S). The carry out of the top byte is discarded.
- R7: Swap writes the payload operand.
- R8: Compare-and-swap writes the swap value only when the original equals the compare value. Otherwise it issues no write.
- R9: A memory word is 16 bytes. The word index is the address above bit 3, the byte lane is address bits [3:0], and byte 0 sits at bits [7:0]. A write goes to the word that was read and enables exactly the S bytes of the operand.
- R10: The request ready signal is high only when idle. For an accepted request the read strobe is high in the cycle after acceptance, the write strobe in the cycle after that, and the completion valid pulse in the third cycle after acceptance. A refused request completes in the first cycle after acceptance. The next request is then served after the completion and sees its write.
- R11: After reset the engine is ready, and completion valid, the read strobe and the write strobe are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request accepted on this edge |
| req_op | input | 2 | Operation code |
| req_len_dw | input | 4 | Payload length in doublewords |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_payload | input | 2*WORD_BYTES*8 | Little-endian operand payload |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W-4 | Memory word index |
| mem_wdata | output | WORD_BYTES*8 | Write data, operand placed in its byte lanes |
| mem_wstrb | output | WORD_BYTES | Byte write enables |
| mem_rdata | input | WORD_BYTES*8 | Read data, valid the cycle after the strobe |
| cpl_valid | output | 1 | Completion pulse |
| cpl_status | output | 2 | 0 success, 1 unsupported, 2 malformed |
| cpl_data | output | WORD_BYTES*8 | Original operand value, zero-extended |

## Verification
Two things can fall in the same cycle: a new request arriving and the completion of the previous one. The question is whether the second request observes the write of the first. To provoke this, the bench raises the next request in the very cycle the completion pulse is seen. It does this for consecutive fetch-and-adds to one address and throughout the random stream. It judges the result against a shadow memory that it updates only from the requirements. Any stale read then shows up as a wrong original value, or as a wrong memory word after the second write.

// File: rtl/atomic_cpl_pkg.sv
// Shared encodings for the atomic completer.
// Assumes a two-bit operation field and a two-bit completion status.
package atomic_cpl_pkg;
    typedef enum logic [1:0] {
        AOP_FADD = 2'd0,
        AOP_SWAP = 2'd1,
        AOP_CAS  = 2'd2,
        AOP_RSVD = 2'd3
    } aop_e;

    typedef enum logic [1:0] {
        CST_OK        = 2'd0,
        CST_UNSUP     = 2'd1,
        CST_MALFORMED = 2'd2
    } cst_e;
endpackage

// File: rtl/atomic_req_check.sv
// Request legality check: maps the operation and doubleword length to an
// operand size (log2 bytes) and flags reserved codes, bad lengths and
// misaligned addresses. Purely combinational; assumes LANE_W >= 4.
module atomic_req_check
    import atomic_cpl_pkg::*;
#(
    parameter int LANE_W = 4
) (
    input  aop_e              op,
    input  logic [3:0]        len_dw,
    input  logic [LANE_W-1:0] lane,
    output cst_e              status,
    output logic [2:0]        size_log
);
    logic              len_ok;
    logic [LANE_W-1:0] align_mask;

    // Decode the operand size allowed for each operation.
    always_comb begin
        size_log = 3'd2;
        len_ok   = 1'b0;
        unique case (op)
            AOP_FADD, AOP_SWAP: begin
                if (len_dw == 4'd1) begin size_log = 3'd2; len_ok = 1'b1; end
                if (len_dw == 4'd2) begin size_log = 3'd3; len_ok = 1'b1; end
            end
            AOP_CAS: begin
                if (len_dw == 4'd2) begin size_log = 3'd2; len_ok = 1'b1; end
                if (len_dw == 4'd4) begin size_log = 3'd3; len_ok = 1'b1; end
                if (len_dw == 4'd8) begin size_log = 3'd4; len_ok = 1'b1; end
            end
            default: len_ok = 1'b0;
        endcase
    end

    // Low address bits that must be zero for natural alignment.
    always_comb begin
        for (int i = 0; i < LANE_W; i++) begin
            align_mask[i] = (i < int'(size_log));
        end
    end

    // Priority: reserved code, then length, then alignment.
    always_comb begin
        if (op == AOP_RSVD)            status = CST_UNSUP;
        else if (!len_ok)              status = CST_MALFORMED;
        else if (|(lane & align_mask)) status = CST_MALFORMED;
        else                           status = CST_OK;
    end
endmodule

// File: rtl/atomic_alu.sv
// Result computation for one atomic operation on an operand of
// 2**size_log bytes held in the low bytes of each input. Bytes above the
// operand are masked, so the add wraps at the operand width.
module atomic_alu
    import atomic_cpl_pkg::*;
#(
    parameter int WORD_W = 128
) (
    input  aop_e              op,
    input  logic [2:0]        size_log,
    input  logic [WORD_W-1:0] fetched,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    output logic [WORD_W-1:0] result,
    output logic              do_write
);
    localparam int NB = WORD_W / 8;

    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] orig_m, a_m, b_m, sum;

    // Build the operand byte mask from the size.
    always_comb begin
        for (int i = 0; i < NB; i++) begin
            mask[i*8 +: 8] = (i < (1 << size_log)) ? 8'hFF : 8'h00;
        end
    end

    assign orig_m = fetched & mask;
    assign a_m    = opa & mask;
    assign b_m    = opb & mask;
    assign sum    = (orig_m + a_m) & mask;

    // Select the new value and decide whether memory is written.
    always_comb begin
        result   = '0;
        do_write = 1'b0;
        unique case (op)
            AOP_FADD: begin result = sum; do_write = 1'b1; end
            AOP_SWAP: begin result = a_m; do_write = 1'b1; end
            AOP_CAS: begin
                result   = b_m;
                do_write = (orig_m == a_m);
            end
            default: begin result = '0; do_write = 1'b0; end
        endcase
    end
endmodule

// File: rtl/atomic_completer.sv
// Atomic completer top: accepts one request when idle, checks it, then
// runs read, modify/write and complete states against a memory with
// one-cycle read latency. Assumes WORD_BYTES >= 16 so that the largest
// operand fits one aligned word.
module atomic_completer
    import atomic_cpl_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int WORD_BYTES = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    output logic                              req_ready,
    input  logic [1:0]                        req_op,
    input  logic [3:0]                        req_len_dw,
    input  logic [ADDR_W-1:0]                 req_addr,
    input  logic [2*WORD_BYTES*8-1:0]         req_payload,
    output logic                              mem_rd_en,
    output logic                              mem_wr_en,
    output logic [ADDR_W-$clog2(WORD_BYTES)-1:0] mem_addr,
    output logic [WORD_BYTES*8-1:0]           mem_wdata,
    output logic [WORD_BYTES-1:0]             mem_wstrb,
    input  logic [WORD_BYTES*8-1:0]           mem_rdata,
    output logic                              cpl_valid,
    output logic [1:0]                        cpl_status,
    output logic [WORD_BYTES*8-1:0]           cpl_data
);
    localparam int WORD_W  = WORD_BYTES * 8;
    localparam int LANE_W  = $clog2(WORD_BYTES);
    localparam int PAY_W   = 2 * WORD_W;
    localparam int MADDR_W = ADDR_W - LANE_W;

    typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_MOD, ST_CPL} fsm_e;

    fsm_e              state;
    aop_e              r_op;
    logic [2:0]        r_size_log;
    logic [MADDR_W-1:0] r_word;
    logic [LANE_W-1:0] r_lane;
    logic [WORD_W-1:0] r_opa, r_opb, r_cpl_data;
    cst_e              r_status;

    cst_e              chk_status;
    logic [2:0]        chk_size_log;
    logic [WORD_W-1:0] in_mask, cur_mask, fetched, alu_result;
    logic [PAY_W-1:0]  pay_hi;
    logic [WORD_BYTES-1:0] strb_base;
    logic              alu_write;
    logic              accept;

    atomic_req_check #(.LANE_W(LANE_W)) u_check (
        .op       (aop_e'(req_op)),
        .len_dw   (req_len_dw),
        .lane     (req_addr[LANE_W-1:0]),
        .status   (chk_status),
        .size_log (chk_size_log)
    );

    // Byte masks for the incoming request and the request in flight.
    always_comb begin
        for (int i = 0; i < WORD_BYTES; i++) begin
            in_mask[i*8 +: 8]  = (i < (1 << chk_size_log)) ? 8'hFF : 8'h00;
            cur_mask[i*8 +: 8] = (i < (1 << r_size_log))   ? 8'hFF : 8'h00;
            strb_base[i]       = (i < (1 << r_size_log));
        end
    end

    assign accept = req_valid && req_ready;
    assign pay_hi = req_payload >> (8 << chk_size_log);

    // Extract the operand lanes from the fetched word.
    assign fetched = (mem_rdata >> {r_lane, 3'b000}) & cur_mask;

    atomic_alu #(.WORD_W(WORD_W)) u_alu (
        .op       (r_op),
        .size_log (r_size_log),
        .fetched  (fetched),
        .opa      (r_opa),
        .opb      (r_opb),
        .result   (alu_result),
        .do_write (alu_write)
    );

    assign req_ready  = (state == ST_IDLE);
    assign mem_rd_en  = (state == ST_RD);
    assign mem_wr_en  = (state == ST_MOD) && alu_write;
    assign mem_addr   = r_word;
    assign mem_wdata  = alu_result << {r_lane, 3'b000};
    assign mem_wstrb  = strb_base << r_lane;
    assign cpl_valid  = (state == ST_CPL);
    assign cpl_status = r_status;
    assign cpl_data   = r_cpl_data;

    // Sequence a request through check, read, modify/write and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            r_op       <= AOP_FADD;
            r_size_log <= 3'd2;
            r_word     <= '0;
            r_lane     <= '0;
            r_opa      <= '0;
            r_opb      <= '0;
            r_status   <= CST_OK;
            r_cpl_data <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    r_op       <= aop_e'(req_op);
                    r_size_log <= chk_size_log;
                    r_word     <= req_addr[ADDR_W-1:LANE_W];
                    r_lane     <= req_addr[LANE_W-1:0];
                    r_opa      <= req_payload[WORD_W-1:0] & in_mask;
                    r_opb      <= pay_hi[WORD_W-1:0] & in_mask;
                    r_status   <= chk_status;
                    r_cpl_data <= '0;
                    state      <= (chk_status == CST_OK) ? ST_RD : ST_CPL;
                end
                ST_RD:  state <= ST_MOD;
                ST_MOD: begin
                    r_cpl_data <= fetched;
                    state      <= ST_CPL;
                end
                ST_CPL: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(mem_rd_en)); // R5
    AST_WRITE_SAME_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_addr == $past(mem_addr))); // R9
    AST_STRB_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($countones(mem_wstrb) == 4 || $countones(mem_wstrb) == 8
                       || $countones(mem_wstrb) == 16)); // R9
    AST_REJECT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_status != CST_OK) |-> (!$past(mem_rd_en) && !$past(mem_wr_en))); // R1
    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R10
    AST_CPL_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_status == CST_OK) |-> $past(mem_rd_en, 2)); // R10
endmodule

// File: tb/atomic_completer_tb.sv
`timescale 1ns/1ps
module atomic_completer_tb;
    localparam int ADDR_W = 8;
    localparam int WB     = 16;
    localparam int WW     = WB * 8;
    localparam int NW     = 1 << (ADDR_W - 4);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_op = '0;
    logic [3:0]        req_len_dw = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [2*WW-1:0]   req_payload = '0;
    logic              mem_rd_en, mem_wr_en;
    logic [ADDR_W-5:0] mem_addr;
    logic [WW-1:0]     mem_wdata;
    logic [WB-1:0]     mem_wstrb;
    logic [WW-1:0]     mem_rdata = '0;
    logic              cpl_valid;
    logic [1:0]        cpl_status;
    logic [WW-1:0]     cpl_data;

    logic [WW-1:0] mem    [NW];
    logic [WW-1:0] shadow [NW];
    int rd_cnt = 0, wr_cnt = 0;
    int checks = 0, failures = 0, cycles = 0;

    always #2 clk = ~clk;

    atomic_completer #(.ADDR_W(ADDR_W), .WORD_BYTES(WB)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_len_dw(req_len_dw), .req_addr(req_addr),
        .req_payload(req_payload), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb),
        .mem_rdata(mem_rdata), .cpl_valid(cpl_valid), .cpl_status(cpl_status),
        .cpl_data(cpl_data)
    );

    // Synchronous memory model with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= mem[mem_addr];
            rd_cnt    <= rd_cnt + 1;
        end
        if (mem_wr_en) begin
            wr_cnt <= wr_cnt + 1;
            for (int b = 0; b < WB; b++)
                if (mem_wstrb[b]) mem[mem_addr][b*8 +: 8] <= mem_wdata[b*8 +: 8];
        end
    end

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog R10 actual=hung expected=done");
            summary();
        end
    end

    task automatic check(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] bmask(input int sz);
        logic [WW-1:0] m;
        for (int i = 0; i < WB; i++) m[i*8 +: 8] = (i < sz) ? 8'hFF : 8'h00;
        return m;
    endfunction

    function automatic int op_size(input logic [1:0] op, input logic [3:0] len);
        if (op == 2'd3) return 0;
        if (op == 2'd2) return (len == 4'd2) ? 4 : (len == 4'd4) ? 8 : (len == 4'd8) ? 16 : 0;
        return (len == 4'd1) ? 4 : (len == 4'd2) ? 8 : 0;
    endfunction

    // Issue one request, predict from the requirements, check everything.
    task automatic run(input logic [1:0] op, input logic [3:0] len,
                       input logic [ADDR_W-1:0] addr, input logic [2*WW-1:0] pay);
        int sz, lane, word, erd, ewr, lat, rd0, wr0;
        logic [1:0] est;
        string tg;
        logic [WW-1:0] orig, a, b, nv, ecpl, m;
        logic [2*WW-1:0] hi;
        sz = op_size(op, len); erd = 0; ewr = 0; ecpl = '0; nv = '0;
        lane = int'(addr[3:0]); word = int'(addr[ADDR_W-1:4]);
        if (op == 2'd3) begin est = 2'd1; tg = "R1"; end
        else if (sz == 0) begin est = 2'd2; tg = "R2"; end
        else if ((int'(addr) % sz) != 0) begin est = 2'd2; tg = "R3"; end
        else begin
            est = 2'd0; erd = 1; m = bmask(sz);
            orig = (shadow[word] >> (lane*8)) & m;
            a = pay[WW-1:0] & m;            // R4: first operand in low bytes
            hi = pay >> (sz*8); b = hi[WW-1:0] & m;
            ecpl = orig;
            case (op)
                2'd0: begin nv = (orig + a) & m; ewr = 1; tg = "R6"; end
                2'd1: begin nv = a; ewr = 1; tg = "R7"; end
                default: begin nv = b; ewr = (orig == a) ? 1 : 0; tg = "R8"; end
            endcase
            if (ewr == 1)
                for (int k = 0; k < sz; k++) shadow[word][(lane+k)*8 +: 8] = nv[k*8 +: 8];
        end
        rd0 = rd_cnt; wr0 = wr_cnt;
        req_op = op; req_len_dw = len; req_addr = addr; req_payload = pay; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1 req_valid = 1'b0;
        lat = 0;
        do begin @(negedge clk); lat++; end while (!cpl_valid && lat < 20);
        check({tg, " status"}, WW'(cpl_status), WW'(est));
        check("R10 latency", WW'(lat), (est == 2'd0) ? WW'(3) : WW'(1));
        if (est == 2'd0) check("R5 original value", cpl_data, ecpl);
        check({tg, " reads"}, WW'(rd_cnt - rd0), WW'(erd));
        check({tg, " writes"}, WW'(wr_cnt - wr0), WW'(ewr));
        for (int w = 0; w < NW; w++) check({tg, " R9 R4 memory"}, mem[w], shadow[w]);
    endtask

    initial begin
        int r, sz;
        logic [1:0] op;
        logic [3:0] len;
        logic [ADDR_W-1:0] addr;
        logic [2*WW-1:0] pay;
        void'($urandom(32'h5eed_a70c));
        for (int w = 0; w < NW; w++) begin
            mem[w] = {$urandom, $urandom, $urandom, $urandom};
            shadow[w] = mem[w];
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check("R11 ready", WW'(req_ready), WW'(1));
        check("R11 cpl_valid", WW'(cpl_valid), WW'(0));
        check("R11 strobes", WW'({mem_rd_en, mem_wr_en}), WW'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R6: carry discarded at 64-bit width, neighbours untouched
        run(2'd1, 4'd2, 8'h18, {192'd0, 64'hFFFF_FFFF_FFFF_FFFF});
        run(2'd0, 4'd2, 8'h18, {192'd0, 64'd1});
        run(2'd0, 4'd1, 8'h1C, {224'd0, 32'h8000_0001});
        // R8: 128-bit compare match then mismatch
        run(2'd2, 4'd8, 8'h20, {128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, shadow[2]});
        run(2'd2, 4'd8, 8'h20, {128'h1, ~shadow[2]});
        // R8: 32-bit compare at the top lane
        run(2'd2, 4'd2, 8'h3C, {192'd0, 32'hCAFE_F00D, shadow[3][127:96]});
        // R3: misaligned, R2: bad lengths, R1: reserved code
        run(2'd0, 4'd2, 8'h04, {256'd5});
        run(2'd2, 4'd4, 8'h44, {256'd5});
        run(2'd2, 4'd1, 8'h40, {256'd5});
        run(2'd0, 4'd4, 8'h40, {256'd5});
        run(2'd3, 4'd1, 8'h40, {256'd5});
        // R10: back-to-back requests to one address see each other's write
        run(2'd0, 4'd1, 8'h30, {224'd0, 32'd7});
        run(2'd0, 4'd1, 8'h30, {224'd0, 32'd9});
        run(2'd1, 4'd1, 8'h34, {224'd0, 32'h1234_5678});

        // Constrained random mix
        for (int i = 0; i < 300; i++) begin
            r = $urandom % 16;
            op = (r < 5) ? 2'd0 : (r < 9) ? 2'd1 : (r < 15) ? 2'd2 : 2'd3;
            r = $urandom % 8;
            if (op == 2'd2) len = (r < 3) ? 4'd2 : (r < 5) ? 4'd4 : (r < 7) ? 4'd8 : 4'($urandom);
            else            len = (r < 4) ? 4'd1 : (r < 7) ? 4'd2 : 4'($urandom);
            sz = op_size(op, len);
            addr = ADDR_W'($urandom);
            if (sz != 0 && ($urandom % 8) != 0) addr = addr & ~ADDR_W'(sz - 1);
            pay = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            if (op == 2'd2 && sz != 0 && ($urandom % 2) == 0)
                pay[WW-1:0] = (shadow[addr[ADDR_W-1:4]] >> (int'(addr[3:0])*8)) & bmask(sz);
            run(op, len, addr, pay);
        end
        summary();
    end
endmodule